// File: doc/BRIEF.md
# Byte-Lane SRAM Select and Acknowledge Generator

This block is the slave-side glue between a 16-bit asynchronous handshake bus and a pair of 2K x 8 static RAMs. One RAM serves the low byte lane (data bits 7:0) and the other the high byte lane (data bits 15:8). The block compares the upper address bits against a fixed region tag and qualifies the hit with the address strobe. It then forms one chip select and one output enable per lane from that lane's data strobe, and produces a shared write enable that can only fall during a write while the address strobe is low.

The bus master waits for an active-low transfer acknowledge. The block holds that acknowledge back for a fixed number of clock edges, counted from the start of a selected access, so that slow memory has time to respond. The acknowledge is released without any clock as soon as the address strobe is negated. The word address bits pass straight through to the eleven RAM address lines.

Top module: `bls_sram_glue`

## Requirements
- R1: `ram_addr_o` equals bus address bits 11:1 (`addr_i[11:1]`) at all times, whatever the strobes are doing.
- R2: The region is hit only when `as_n` is low and `addr_i[23:12]` equals `REGION_TAG`. When there is no hit, every chip select, output enable and write enable and `dtack_n` stays high.
- R3: `cs_lo_n` is low exactly when the region is hit and `lds_n` is low.
- R4: `cs_hi_n` is low exactly when the region is hit and `uds_n` is low.
- R5: `we_n` is low exactly when the region is hit and `rd_wr` is 0 (write). `rd_wr` = 1 means read.
- R6: `oe_lo_n` is low exactly when the region is hit, `rd_wr` is 1 and `lds_n` is low. `oe_hi_n` follows the same rule with `uds_n`. An output enable and the write enable are never active together.
- R7: An access is active while at least one chip select is low. `dtack_n` goes low after exactly `WAIT_STATES` rising clock edges of an active access, and it stays low while the access continues.
- R8: `dtack_n` returns high in the same instant that `as_n` rises, with no clock edge needed. An access that starts after at least one edge with `as_n` high again waits the full `WAIT_STATES` edges.
- R9: While `rst_n` is low, `dtack_n` is high even during a selected access. Once reset is released, the wait count starts from zero.
- R10: A region hit with both data strobes high never produces an acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that counts wait states |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| addr_i | input | 23 | Bus word address, bits 23:1 |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe (bits 15:8), active low |
| lds_n | input | 1 | Lower data strobe (bits 7:0), active low |
| rd_wr | input | 1 | 1 = read cycle, 0 = write cycle |
| ram_addr_o | output | 11 | Address to both RAMs |
| cs_lo_n | output | 1 | Low-lane RAM chip select |
| cs_hi_n | output | 1 | High-lane RAM chip select |
| we_n | output | 1 | Shared RAM write enable |
| oe_lo_n | output | 1 | Low-lane RAM output enable |
| oe_hi_n | output | 1 | High-lane RAM output enable |
| dtack_n | output | 1 | Transfer acknowledge, active low |

## Verification
Two events can land on the same clock edge: the negation of the address strobe and the edge on which the wait counter would reach its limit. The bench raises `as_n` in the cycle just before that edge. It checks that `dtack_n` never falls, and that a new access started on the next cycle still waits the full count. A second overlap puts the reset release in the middle of a selected access; that acknowledge is timed from the release. Random accesses with mixed tags, strobes and directions are checked against bench functions for every select and enable, and for the exact edge on which the acknowledge falls.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_LO   = 0;
  localparam int unsigned LANE_HI   = 1;

  typedef enum logic {
    XFER_WRITE = 1'b0,
    XFER_READ  = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/bls_region_decode.sv
module bls_region_decode #(
  parameter int unsigned TAG_W      = 12,
  parameter int unsigned REGION_TAG = 'h0A5
) (
  input  logic [TAG_W-1:0] tag_i,
  input  logic             as_n,
  output logic             hit_o
);
  localparam logic [TAG_W-1:0] TAG_C = TAG_W'(REGION_TAG);

  always_comb begin
    hit_o = (!as_n) && (tag_i == TAG_C);
  end
endmodule

// File: rtl/bls_lane_gate.sv
module bls_lane_gate
  import bls_pkg::*;
#(
  parameter int unsigned LANES = NUM_LANES
) (
  input  logic             hit_i,
  input  xfer_dir_e        dir_i,
  input  logic [LANES-1:0] strb_n_i,
  output logic [LANES-1:0] cs_n_o,
  output logic [LANES-1:0] oe_n_o,
  output logic             we_n_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_on;
    always_comb begin
      lane_on   = hit_i && !strb_n_i[g];
      cs_n_o[g] = !lane_on;
      oe_n_o[g] = !(lane_on && (dir_i == XFER_READ));
    end
  end

  always_comb begin
    we_n_o = !(hit_i && (dir_i == XFER_WRITE));
  end
endmodule

// File: rtl/bls_ack_timer.sv
module bls_ack_timer #(
  parameter int unsigned WAIT_STATES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic access_i,
  output logic ack_n_o
);
  localparam int unsigned CNT_W = $clog2(WAIT_STATES + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_STATES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_limit;

  always_comb begin
    at_limit = (cnt_q == LIMIT);
    cnt_en   = access_i || (cnt_q != '0);
    if (!access_i) begin
      cnt_d = '0;
    end else if (at_limit) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    ack_n_o = !(access_i && at_limit && rst_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/bls_sram_glue.sv
module bls_sram_glue
  import bls_pkg::*;
#(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned RAM_AW      = 11,
  parameter int unsigned REGION_TAG  = 'h0A5,
  parameter int unsigned WAIT_STATES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic              as_n,
  input  logic              uds_n,
  input  logic              lds_n,
  input  logic              rd_wr,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              cs_lo_n,
  output logic              cs_hi_n,
  output logic              we_n,
  output logic              oe_lo_n,
  output logic              oe_hi_n,
  output logic              dtack_n
);
  localparam int unsigned TAG_W = ADDR_W - 1 - RAM_AW;

  logic                 hit;
  logic                 access;
  logic [NUM_LANES-1:0] strb_n;
  logic [NUM_LANES-1:0] cs_n;
  logic [NUM_LANES-1:0] oe_n;
  xfer_dir_e            dir;

  always_comb begin
    ram_addr_o      = addr_i[RAM_AW:1];
    strb_n[LANE_LO] = lds_n;
    strb_n[LANE_HI] = uds_n;
    dir             = xfer_dir_e'(rd_wr);
  end

  bls_region_decode #(
    .TAG_W     (TAG_W),
    .REGION_TAG(REGION_TAG)
  ) u_decode (
    .tag_i(addr_i[ADDR_W-1:RAM_AW+1]),
    .as_n (as_n),
    .hit_o(hit)
  );

  bls_lane_gate #(
    .LANES(NUM_LANES)
  ) u_lanes (
    .hit_i   (hit),
    .dir_i   (dir),
    .strb_n_i(strb_n),
    .cs_n_o  (cs_n),
    .oe_n_o  (oe_n),
    .we_n_o  (we_n)
  );

  always_comb begin
    cs_lo_n = cs_n[LANE_LO];
    cs_hi_n = cs_n[LANE_HI];
    oe_lo_n = oe_n[LANE_LO];
    oe_hi_n = oe_n[LANE_HI];
    access  = !(&cs_n);
  end

  bls_ack_timer #(
    .WAIT_STATES(WAIT_STATES)
  ) u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .access_i(access),
    .ack_n_o (dtack_n)
  );
endmodule

// File: rtl/bls_sram_glue_chk.sv
module bls_sram_glue_chk #(
  parameter int unsigned WAIT_STATES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic as_n,
  input logic uds_n,
  input logic lds_n,
  input logic rd_wr,
  input logic cs_lo_n,
  input logic cs_hi_n,
  input logic we_n,
  input logic oe_lo_n,
  input logic oe_hi_n,
  input logic dtack_n
);
  logic        live;
  int unsigned seen_q;

  always_comb begin
    live = !cs_lo_n || !cs_hi_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 0;
    end else if (!live) begin
      seen_q <= 0;
    end else if (seen_q < WAIT_STATES) begin
      seen_q <= seen_q + 1;
    end
  end

  assert_strobe_gates_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> dtack_n);
  assert_lo_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lo_n |-> (!lds_n && !as_n));
  assert_hi_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_hi_n |-> (!uds_n && !as_n));
  assert_write_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!rd_wr && !as_n));
  assert_no_drive_clash_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (oe_lo_n && oe_hi_n));
  assert_ack_not_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> (live && seen_q == WAIT_STATES));
  assert_ack_on_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live && seen_q == WAIT_STATES) |-> !dtack_n);
  assert_ack_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (uds_n && lds_n) |-> dtack_n);
endmodule

bind bls_sram_glue bls_sram_glue_chk #(
  .WAIT_STATES(WAIT_STATES)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .as_n   (as_n),
  .uds_n  (uds_n),
  .lds_n  (lds_n),
  .rd_wr  (rd_wr),
  .cs_lo_n(cs_lo_n),
  .cs_hi_n(cs_hi_n),
  .we_n   (we_n),
  .oe_lo_n(oe_lo_n),
  .oe_hi_n(oe_hi_n),
  .dtack_n(dtack_n)
);

// File: tb/bls_sram_glue_tb.sv
module bls_sram_glue_tb;
  localparam int unsigned WS  = 3;
  localparam logic [11:0] TAG = 12'h0A5;

  logic        clk;
  logic        rst_n;
  logic [23:1] addr;
  logic        as_n, uds_n, lds_n, rd_wr;
  logic [10:0] ram_addr;
  logic        cs_lo_n, cs_hi_n, we_n, oe_lo_n, oe_hi_n, dtack_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  bls_sram_glue #(
    .ADDR_W(24), .RAM_AW(11), .REGION_TAG(32'h0A5), .WAIT_STATES(WS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .as_n(as_n), .uds_n(uds_n),
    .lds_n(lds_n), .rd_wr(rd_wr), .ram_addr_o(ram_addr), .cs_lo_n(cs_lo_n),
    .cs_hi_n(cs_hi_n), .we_n(we_n), .oe_lo_n(oe_lo_n), .oe_hi_n(oe_hi_n),
    .dtack_n(dtack_n)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic bit f_hit(logic [23:1] a, logic as);
    return !as && (a[23:12] == TAG);
  endfunction

  function automatic logic [5:0] f_pins(logic [23:1] a, logic as, logic u, logic l, logic r);
    bit h = f_hit(a, as);
    // {cs_lo_n, cs_hi_n, we_n, oe_lo_n, oe_hi_n, ack_possible}
    return {!(h && !l), !(h && !u), !(h && !r), !(h && r && !l), !(h && r && !u),
            h && (!l || !u)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_static();
    logic [5:0] e = f_pins(addr, as_n, uds_n, lds_n, rd_wr);
    chk("R1 ram_addr", 32'(ram_addr), 32'(addr[11:1]));
    chk("R3 cs_lo_n", 32'(cs_lo_n), 32'(e[5]));
    chk("R4 cs_hi_n", 32'(cs_hi_n), 32'(e[4]));
    chk("R5 we_n", 32'(we_n), 32'(e[3]));
    chk("R6 oe_lo_n", 32'(oe_lo_n), 32'(e[2]));
    chk("R6 oe_hi_n", 32'(oe_hi_n), 32'(e[1]));
  endtask

  // one full access: strobes low just after an edge, timed ack, then release
  task automatic access(logic [23:1] a, logic u, logic l, logic r);
    logic [5:0] e;
    addr = a; uds_n = u; lds_n = l; rd_wr = r; as_n = 1'b0;
    #1;
    e = f_pins(a, 1'b0, u, l, r);
    check_static();
    for (int k = 0; k < WS; k++) begin
      chk("R7 ack held off", 32'(dtack_n), 32'd1);
      step();
    end
    chk(e[0] ? "R7 ack after wait" : "R10/R2 no ack", 32'(dtack_n), 32'(!e[0]));
    step();
    chk("R7 ack held", 32'(dtack_n), 32'(!e[0]));
    as_n = 1'b1;
    #0.5;
    chk("R8 immediate release", 32'(dtack_n), 32'd1);
    check_static();
    #0.5;
    step();
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [23:1] a;
    void'($urandom(32'd1234));
    rst_n = 0; addr = '0; as_n = 1; uds_n = 1; lds_n = 1; rd_wr = 1;
    step(); step();
    chk("R9 reset dtack", 32'(dtack_n), 32'd1);
    chk("R2 idle we_n", 32'(we_n), 32'd1);

    // R9: selected access spanning reset release
    addr = {TAG, 11'h155}; as_n = 0; lds_n = 0; uds_n = 0; rd_wr = 1;
    step(); step(); step(); step();
    chk("R9 no ack in reset", 32'(dtack_n), 32'd1);
    rst_n = 1;
    for (int k = 0; k < WS; k++) begin
      chk("R9 wait from release", 32'(dtack_n), 32'd1);
      step();
    end
    chk("R9 ack after release", 32'(dtack_n), 32'd0);
    as_n = 1; uds_n = 1; lds_n = 1;
    step();

    // directed lanes and directions
    access({TAG, 11'h001}, 1'b1, 1'b0, 1'b1);  // R3 low byte read
    access({TAG, 11'h7FF}, 1'b0, 1'b1, 1'b0);  // R4 high byte write
    access({TAG, 11'h2AA}, 1'b0, 1'b0, 1'b0);  // R5 word write
    access({TAG, 11'h0F0}, 1'b1, 1'b1, 1'b1);  // R10 no strobes
    access({12'h0A4, 11'h0F0}, 1'b0, 1'b0, 1'b1);  // R2 miss

    // R8 corner: strobe negated just before the edge that would reach the limit
    addr = {TAG, 11'h033}; uds_n = 0; lds_n = 0; rd_wr = 1; as_n = 0;
    for (int k = 0; k < WS - 1; k++) step();
    chk("R8 pre-limit", 32'(dtack_n), 32'd1);
    as_n = 1;
    step();
    chk("R8 aborted no ack", 32'(dtack_n), 32'd1);
    as_n = 0;
    for (int k = 0; k < WS; k++) begin
      chk("R8 full wait again", 32'(dtack_n), 32'd1);
      step();
    end
    chk("R8 ack after restart", 32'(dtack_n), 32'd0);
    as_n = 1; uds_n = 1; lds_n = 1;
    step();

    // R1 with strobes idle
    addr = 23'h5ABCD;
    #1;
    chk("R1 idle passthrough", 32'(ram_addr), 32'(addr[11:1]));

    // constrained random
    for (int i = 0; i < 60; i++) begin
      a = 23'($urandom());
      if ($urandom_range(1, 0) == 1) a[23:12] = TAG;
      access(a, 1'($urandom()), 1'($urandom()), 1'($urandom()));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule